// File: doc/BRIEF.md
# Flash Status Pin Configuration Controller

This block drives the status output pin of a flash memory's embedded erase/program state machine. After reset the pin shows the sequencer's ready/busy level: high when idle, low while an erase or program is running. Software can instead turn the pin into a completion interrupt. In that mode the pin idles high and drops low for a fixed number of clock cycles when an erase finishes, when a program finishes, or when either finishes.

The mode is chosen by a two-write command on a simple command bus. Each write is a strobe plus an 8-bit byte. The first write carries the opcode B8h. The second write carries a byte whose two low bits select the mode, and its upper six bits are ignored. The sequencer itself is not part of this block. It appears only as a busy level and two single-cycle done strobes.

Top module: `flash_status_pin`

## Requirements
- R1: After reset the mode is level (code 00), no configuration sequence is pending, and the pin is high while `seq_busy` is low.
- R2: A write of B8h followed by a second write of any byte other than B8h sets the mode to bits [1:0] of that second byte. Bits [7:2] have no effect. The new mode governs strobes from the cycle after the second write.
- R3: In level mode (code 00) the pin equals the inverse of `seq_busy` as sampled on the previous clock edge. Done strobes never pulse the pin in this mode.
- R4: In mode 01 an `erase_done` strobe drives the pin low, and `prog_done` has no effect.
- R5: In mode 10 a `prog_done` strobe drives the pin low, and `erase_done` has no effect.
- R6: In mode 11 either strobe drives the pin low.
- R7: A pulse starts in the cycle after the strobe and keeps the pin low for exactly `PULSE_CYCLES` consecutive cycles before the pin returns high.
- R8: In any pulse mode (01, 10, 11) the pin stays high while `seq_busy` is high and no pulse is active.
- R9: An enabled strobe that arrives during an active pulse restarts the low time at the full `PULSE_CYCLES`.
- R10: If B8h is pending and the next write is B8h again, the sequence is abandoned. The mode is kept, and the write that follows is decoded as a first write.
- R11: A completed configuration sequence that arrives while a pulse is active, other than in the pulse's final cycle, is held back. It takes effect in the cycle after the pulse ends.
- R12: A first write of any byte other than B8h leaves the mode unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command write strobe, one cycle per byte |
| cmd_data | input | 8 | Command byte |
| seq_busy | input | 1 | Sequencer busy level |
| erase_done | input | 1 | Single-cycle strobe: erase or queued erase run finished |
| prog_done | input | 1 | Single-cycle strobe: program finished |
| status_pin | output | 1 | Status pin, 1 = high/released, 0 = driven low |

## Verification
The bench sweeps all four mode codes, each written with several patterns in the reserved upper bits. For every mode it counts the low cycles produced by an erase strobe and by a program strobe. A decoder that let the upper bits leak into the mode, or mis-wired a mask bit, would pulse on the wrong operation or give the wrong count. It also checks four corner cases:
- A retrigger in the middle of a pulse. A timer that ignores it gives a pulse that is too short.
- A doubled opcode. A decoder that stays armed would turn the next byte into a mode change.
- A configuration written during a pulse. Applying it at once would cut the pulse short or switch the pin to the busy level early.
- A busy level in pulse mode, which must not pull the pin low.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

    typedef enum logic [1:0] {
        MODE_LEVEL = 2'b00,
        MODE_ERASE = 2'b01,
        MODE_PROG  = 2'b10,
        MODE_ANY   = 2'b11
    } sts_mode_e;

    localparam logic [7:0] CFG_OPCODE = 8'hB8;

    typedef struct packed {
        logic armed;
    } dec_state_t;

    typedef struct packed {
        sts_mode_e mode;
        logic      pend_vld;
        sts_mode_e pend_mode;
        logic      busy;
    } top_state_t;

endpackage

// File: rtl/fsp_cmd_decode.sv
module fsp_cmd_decode
    import fsp_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_we,
    input  logic [7:0]      cmd_data,
    output logic            cfg_fire,
    output sts_mode_e       cfg_code,
    output logic            armed
);

    dec_state_t st_q, st_d;
    logic       is_opcode;

    assign is_opcode = (cmd_data == CFG_OPCODE);

    always_comb begin
        st_d     = st_q;
        cfg_fire = 1'b0;
        cfg_code = sts_mode_e'(cmd_data[1:0]);
        if (cmd_we) begin
            if (!st_q.armed) begin
                st_d.armed = is_opcode;
            end else begin
                // second write: a repeated opcode abandons, anything else configures
                st_d.armed = 1'b0;
                cfg_fire   = !is_opcode;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.armed <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign armed = st_q.armed;

    AST_ABANDON: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.armed && cmd_we && is_opcode) |=> !st_q.armed); // R10

    AST_FIRST_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.armed) |-> !cfg_fire); // R12

endmodule

// File: rtl/fsp_pulse_timer.sv
module fsp_pulse_timer #(
    parameter int PULSE_CYCLES = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic active,
    output logic ending
);

    localparam int CNT_W = $clog2(PULSE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_CYCLES);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (trig) begin
            cnt_d = CNT_LOAD;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CNT_ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign active = (cnt_q != '0);
    assign ending = (cnt_q == CNT_ONE) && !trig;

    AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> (cnt_q == CNT_LOAD)); // R9

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_LOAD); // R7

    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !trig) |=> (cnt_q == $past(cnt_q) - CNT_ONE)); // R7

endmodule

// File: rtl/flash_status_pin.sv
module flash_status_pin
    import fsp_pkg::*;
#(
    parameter int PULSE_CYCLES = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_we,
    input  logic [7:0] cmd_data,
    input  logic       seq_busy,
    input  logic       erase_done,
    input  logic       prog_done,
    output logic       status_pin
);

    top_state_t st_q, st_d;
    logic       cfg_fire;
    sts_mode_e  cfg_code;
    logic       armed;
    logic       trig;
    logic       pulse_active;
    logic       pulse_ending;

    fsp_cmd_decode u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_we   (cmd_we),
        .cmd_data (cmd_data),
        .cfg_fire (cfg_fire),
        .cfg_code (cfg_code),
        .armed    (armed)
    );

    assign trig = (st_q.mode[0] && erase_done) || (st_q.mode[1] && prog_done);

    fsp_pulse_timer #(.PULSE_CYCLES(PULSE_CYCLES)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig   (trig),
        .active (pulse_active),
        .ending (pulse_ending)
    );

    always_comb begin
        st_d      = st_q;
        st_d.busy = seq_busy;
        if (pulse_ending) begin
            if (st_q.pend_vld) begin
                st_d.mode = st_q.pend_mode;
            end
            st_d.pend_vld = 1'b0;
        end
        if (cfg_fire) begin
            if (pulse_active && !pulse_ending) begin
                st_d.pend_vld  = 1'b1;
                st_d.pend_mode = cfg_code;
            end else begin
                st_d.mode = cfg_code;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode      <= MODE_LEVEL;
            st_q.pend_vld  <= 1'b0;
            st_q.pend_mode <= MODE_LEVEL;
            st_q.busy      <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_pin = (st_q.mode == MODE_LEVEL) ? !st_q.busy : !pulse_active;

    AST_LEVEL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_LEVEL && !pulse_active && seq_busy && !cfg_fire)
        |=> !status_pin); // R3

    AST_ERASE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_ERASE && erase_done && !cfg_fire && !pulse_ending)
        |=> !status_pin); // R4

    AST_PROG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_ERASE && prog_done && !erase_done && !pulse_active && !cfg_fire)
        |=> status_pin); // R4

    AST_DEFER: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_fire && pulse_active && !pulse_ending) |=> $stable(st_q.mode)); // R11

    AST_NO_ARM_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !pulse_ending) |=> $stable(st_q.mode)); // R12

endmodule

// File: tb/flash_status_pin_bench.sv
module flash_status_pin_bench;

    localparam int PW = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_we = 1'b0;
    logic [7:0] cmd_data = 8'h00;
    logic       seq_busy = 1'b0;
    logic       erase_done = 1'b0;
    logic       prog_done = 1'b0;
    logic       status_pin;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    flash_status_pin #(.PULSE_CYCLES(PW)) u_flash_status_pin (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_we     (cmd_we),
        .cmd_data   (cmd_data),
        .seq_busy   (seq_busy),
        .erase_done (erase_done),
        .prog_done  (prog_done),
        .status_pin (status_pin)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] b);
        cmd_we = 1'b1; cmd_data = b;
        @(negedge clk);
        cmd_we = 1'b0; cmd_data = 8'h00;
    endtask

    task automatic configure(input logic [7:0] b);
        wr(8'hB8);
        wr(b);
    endtask

    // fire a strobe, return number of low cycles and first-sample value
    task automatic strobe(input bit er, input bit pr, output int lows, output int first);
        erase_done = er; prog_done = pr;
        @(negedge clk);
        erase_done = 1'b0; prog_done = 1'b0;
        lows = 0;
        first = status_pin;
        for (int i = 0; i < PW + 4; i++) begin
            if (!status_pin) lows++;
            @(negedge clk);
        end
    endtask

    initial begin
        int lows, first;
        logic [7:0] uppers [4];
        uppers[0] = 8'h00; uppers[1] = 8'hFC; uppers[2] = 8'h54; uppers[3] = 8'hA8;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 pin after reset", status_pin, 1);
        seq_busy = 1'b1; @(negedge clk); @(negedge clk);
        check("R1 level mode after reset busy", status_pin, 0);
        seq_busy = 1'b0; @(negedge clk); @(negedge clk);
        check("R3 level ready", status_pin, 1);
        strobe(1, 1, lows, first);
        check("R3 no pulse in level mode", lows, 0);

        // sweep of mode codes and reserved bits
        for (int m = 0; m < 4; m++) begin
            for (int u = 0; u < 4; u++) begin
                configure((uppers[u] & 8'hFC) | 8'(m) | ((uppers[u] == 8'hB8) ? 8'h00 : 8'h00));
                strobe(1, 0, lows, first);
                check($sformatf("R2 R4 R6 erase m=%0d u=%0d", m, u), lows, (m & 1) ? PW : 0);
                if (m & 1) check("R7 pulse starts next cycle", first, 0);
                strobe(0, 1, lows, first);
                check($sformatf("R2 R5 R6 prog m=%0d u=%0d", m, u), lows, (m & 2) ? PW : 0);
                if (m != 0) begin
                    seq_busy = 1'b1; @(negedge clk); @(negedge clk);
                    check("R8 busy ignored in pulse mode", status_pin, 1);
                    seq_busy = 1'b0; @(negedge clk);
                end
            end
        end

        // retrigger: mode 11
        configure(8'h03);
        erase_done = 1'b1; @(negedge clk); erase_done = 1'b0;
        repeat (3) @(negedge clk);
        strobe(0, 1, lows, first);
        check("R9 retrigger full width", lows, PW);

        // abandon: in mode 11, B8 B8 01 must keep mode 11
        wr(8'hB8); wr(8'hB8); wr(8'h01);
        strobe(0, 1, lows, first);
        check("R10 abandon keeps mode", lows, PW);
        // R12: lone byte is not a configuration
        wr(8'h02);
        strobe(1, 0, lows, first);
        check("R12 lone byte ignored", lows, PW);

        // deferral: mode 01, start pulse, configure level during it
        configure(8'h01);
        seq_busy = 1'b1;
        erase_done = 1'b1; @(negedge clk); erase_done = 1'b0;
        configure(8'h00);
        check("R11 pulse still low after cfg", status_pin, 0);
        lows = 2;
        for (int i = 0; i < PW + 4; i++) begin
            if (i < PW - 2 && !status_pin) lows++;
            @(negedge clk);
        end
        check("R11 pulse kept full width", lows, PW);
        check("R11 level mode after pulse", status_pin, 0);
        seq_busy = 1'b0; @(negedge clk); @(negedge clk);
        check("R11 level ready", status_pin, 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule